// File: doc/BRIEF.md
# Fetch Next-Address Selector with Target Cache and Return Stack

This block chooses, once per cycle, the address the fetch stage of a 32-bit RISC-V pipeline reads next. It looks at the current fetch address and the instruction word fetched from it. It takes a taken/not-taken guess from an external direction predictor. It also takes a correction from the decode stage, which carries the right address after a misprediction. Three predictors feed the choice, so that correctly guessed control transfers cost no bubble. The first is a direct-mapped, tagged cache of branch targets. The second is a decoder that works out the target of a direct jump-and-link (JAL) in the fetch cycle. The third is a small stack that remembers the return addresses of calls.

The output address goes back to the PC register. The predicted-taken flag travels down the pipeline with the instruction, so that the decode stage can tell whether its own resolution disagrees. When the decode stage resolves a taken branch whose target was missing or wrong, it writes the target cache through the update port.

Top module: `fetch_npc`

## Requirements
- R1: After reset every target-cache entry is invalid and the return stack is empty. A non-jump instruction then gives next_pc_o = pc_i + 4 and pred_taken_o = 0, even with dir_taken_i high, and a return also gives pc_i + 4.
- R2: The target cache has 256 entries indexed by pc_i[9:2]. A hit needs a valid entry whose stored tag equals pc_i[31:10]. On a hit with dir_taken_i = 1 the output is the stored target with pred_taken_o = 1. On a hit with dir_taken_i = 0, or on a miss, the output is pc_i + 4 with pred_taken_o = 0.
- R3: upd_valid_i writes entry upd_pc_i[9:2] with tag upd_pc_i[31:10] and target upd_target_i[31:2], and sets its valid bit, all at the next clock edge. A write to an occupied index replaces the old entry. A lookup in the write cycle sees the old contents.
- R4: A JAL is recognised by opcode 1101111. Its immediate is bit 20 = instr[31], bits 10:1 = instr[30:21], bit 11 = instr[20], bits 19:12 = instr[19:12], bit 0 = 0, sign-extended from bit 20. The output is pc_i plus that immediate, with pred_taken_o = 1.
- R5: A call is a JAL, or a JALR (opcode 1100111, funct3 instr[14:12] = 000), whose rd = instr[11:7] is 1 or 5. A call pushes pc_i + 4 onto the return stack.
- R6: A return is a JALR with rd = 0 and rs1 = instr[19:15] equal to 1 or 5. It pops the stack, and the output is the popped address with pred_taken_o = 1. On an empty stack a return gives pc_i + 4 with pred_taken_o = 0 and leaves the stack unchanged. A JALR with any other rs1 does not pop.
- R7: The return stack holds 8 entries. A ninth push without pops overwrites the oldest entry, so eight pops then give the eight newest pushes, newest first, and the stack is then empty.
- R8: redir_valid_i = 1 forces next_pc_o = redir_pc_i and pred_taken_o = 0 over every other source. In that cycle the return stack neither pushes nor pops.
- R9: When no redirect is present, the sources rank as follows, highest first: a return with a non-empty stack, then JAL, then a target-cache hit with dir_taken_i = 1, then pc_i + 4.
- R10: A JALR call is not predicted by the jump decoder. Its output comes from the target cache or pc_i + 4, and it still pushes its return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Current fetch address |
| instr_i | input | 32 | Instruction word fetched at pc_i |
| dir_taken_i | input | 1 | Direction guess for the instruction at pc_i |
| redir_valid_i | input | 1 | Decode-stage correction present |
| redir_pc_i | input | 32 | Corrected fetch address |
| upd_valid_i | input | 1 | Write one target-cache entry |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_target_i | input | 32 | Resolved taken target |
| next_pc_o | output | 32 | Selected next fetch address |
| pred_taken_o | output | 1 | Next address is a predicted taken transfer |

## Verification
The two functions that collide are a decode-stage redirect and a stack push or pop requested by the wrong-path instruction fetched in the same cycle. The bench first leaves one known address on the stack. It then presents a return, and after that a call, each together with a redirect, and judges the output in those cycles against the redirect address. It then sends two more returns. The first must give back the address saved earlier and the second must find the stack empty, which shows that the redirect cycles neither popped nor pushed. A second collision, a cache write and a lookup of the same index in one cycle, is checked the same way: the old entry must be seen in that cycle and the new one afterwards.

// File: rtl/fnpc_pkg.sv
package fnpc_pkg;
  localparam logic [6:0] OPC_JAL  = 7'b1101111;
  localparam logic [6:0] OPC_JALR = 7'b1100111;

  function automatic logic is_link(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  typedef struct packed {
    logic        jal;
    logic        call;
    logic        ret;
    logic [31:0] jal_off;
  } predec_t;
endpackage

// File: rtl/fnpc_predec.sv
module fnpc_predec
  import fnpc_pkg::*;
(
  input  logic [31:0] instr_i,
  output predec_t     dec_o
);
  logic [4:0] rd, rs1;
  logic       is_jalr;

  assign rd      = instr_i[11:7];
  assign rs1     = instr_i[19:15];
  assign is_jalr = (instr_i[6:0] == OPC_JALR) && (instr_i[14:12] == 3'b000);

  always_comb begin
    dec_o.jal     = (instr_i[6:0] == OPC_JAL);
    dec_o.call    = (dec_o.jal || is_jalr) && is_link(rd);
    dec_o.ret     = is_jalr && (rd == 5'd0) && is_link(rs1);
    dec_o.jal_off = {{12{instr_i[31]}}, instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
  end
endmodule

// File: rtl/fnpc_btb.sv
module fnpc_btb #(
  parameter int IDX_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:2] rd_pc_i,
  output logic        hit_o,
  output logic [31:2] tgt_o,
  input  logic        wr_en_i,
  input  logic [31:2] wr_pc_i,
  input  logic [31:2] wr_tgt_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = 30 - IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [31:2]        tgt_q [ENTRIES];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx = rd_pc_i[IDX_W+1:2];
  assign rd_tag = rd_pc_i[31:IDX_W+2];
  assign wr_idx = wr_pc_i[IDX_W+1:2];
  assign wr_tag = wr_pc_i[31:IDX_W+2];

  // lookup reads pre-write contents
  assign hit_o = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign tgt_o = tgt_q[rd_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt_i;
    end
  end

  assert_wr_sets_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/fnpc_ras.sv
module fnpc_ras #(
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [31:0]              push_val_i,
  input  logic                     pop_i,
  output logic [31:0]              top_o,
  output logic [$clog2(DEPTH):0]   cnt_o
);
  localparam int PW    = $clog2(DEPTH);
  localparam int CNT_W = PW + 1;

  logic [31:0]    mem_q [DEPTH];
  logic [PW-1:0]  ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic           full, empty;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign top_o = mem_q[ptr_q - 1'b1];
  assign cnt_o = cnt_q;

  // circular: overflow overwrites the oldest slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_q + 1'b1;
      if (!full) cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && !empty) begin
      ptr_q <= ptr_q - 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[ptr_q] <= push_val_i;
  end

  assert_push_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_val_i));
  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_cnt_grow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_empty_pop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> cnt_q == '0);
endmodule

// File: rtl/fetch_npc.sv
module fetch_npc
  import fnpc_pkg::*;
#(
  parameter int BTB_IDX_W = 8,
  parameter int RAS_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] pc_i,
  input  logic [31:0] instr_i,
  input  logic        dir_taken_i,
  input  logic        redir_valid_i,
  input  logic [31:0] redir_pc_i,
  input  logic        upd_valid_i,
  input  logic [31:0] upd_pc_i,
  input  logic [31:0] upd_target_i,
  output logic [31:0] next_pc_o,
  output logic        pred_taken_o
);
  localparam int CNT_W = $clog2(RAS_DEPTH) + 1;

  predec_t          dec;
  logic             btb_hit;
  logic [31:2]      btb_tgt;
  logic [31:0]      ras_top, pc_plus4;
  logic [CNT_W-1:0] ras_cnt;
  logic             ras_push, ras_pop, ras_empty;
  logic             unused_low;

  assign unused_low = ^{upd_pc_i[1:0], upd_target_i[1:0]};
  assign pc_plus4   = pc_i + 32'd4;

  fnpc_predec u_predec (.instr_i(instr_i), .dec_o(dec));

  fnpc_btb #(.IDX_W(BTB_IDX_W)) u_btb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_pc_i (pc_i[31:2]),
    .hit_o   (btb_hit),
    .tgt_o   (btb_tgt),
    .wr_en_i (upd_valid_i),
    .wr_pc_i (upd_pc_i[31:2]),
    .wr_tgt_i(upd_target_i[31:2])
  );

  // wrong-path fetch under redirect must not touch the stack
  assign ras_push  = !redir_valid_i && dec.call;
  assign ras_pop   = !redir_valid_i && dec.ret;
  assign ras_empty = (ras_cnt == '0);

  fnpc_ras #(.DEPTH(RAS_DEPTH)) u_ras (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ras_push),
    .push_val_i(pc_plus4),
    .pop_i     (ras_pop),
    .top_o     (ras_top),
    .cnt_o     (ras_cnt)
  );

  always_comb begin
    next_pc_o    = pc_plus4;
    pred_taken_o = 1'b0;
    if (redir_valid_i) begin
      next_pc_o = redir_pc_i;
    end else if (dec.ret) begin
      if (!ras_empty) begin
        next_pc_o    = ras_top;
        pred_taken_o = 1'b1;
      end
    end else if (dec.jal) begin
      next_pc_o    = pc_i + dec.jal_off;
      pred_taken_o = 1'b1;
    end else if (btb_hit && dir_taken_i) begin
      next_pc_o    = {btb_tgt, 2'b00};
      pred_taken_o = 1'b1;
    end
  end

  assert_redir_freezes_stack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_i |=> ras_cnt == $past(ras_cnt));
  assert_redir_not_pred_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redir_valid_i |-> !pred_taken_o && (next_pc_o == redir_pc_i));
endmodule

// File: tb/sim_fetch_npc.sv
`timescale 1ns/1ps
module sim_fetch_npc;
  localparam logic [31:0] NOP = 32'h00000013;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] pc_i = '0, instr_i = NOP, redir_pc_i = '0, upd_pc_i = '0, upd_target_i = '0;
  logic dir_taken_i = 1'b0, redir_valid_i = 1'b0, upd_valid_i = 1'b0;
  logic [31:0] next_pc_o;
  logic pred_taken_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_npc u0 (.clk_i(clk), .rst_ni(rst_ni), .pc_i(pc_i), .instr_i(instr_i),
    .dir_taken_i(dir_taken_i), .redir_valid_i(redir_valid_i), .redir_pc_i(redir_pc_i),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_target_i(upd_target_i),
    .next_pc_o(next_pc_o), .pred_taken_o(pred_taken_o));

  function automatic logic [31:0] enc_jal(input logic [4:0] rd, input logic [20:0] imm);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_jalr(input logic [4:0] rd, input logic [4:0] rs1);
    return {12'h000, rs1, 3'b000, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] pc_at(input logic [21:0] tag, input int idx);
    return {tag, idx[7:0], 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [31:0] ins, input logic dt,
                       input logic rv, input logic [31:0] rpc,
                       input logic uv, input logic [31:0] upc, input logic [31:0] utg);
    @(negedge clk);
    pc_i = pc; instr_i = ins; dir_taken_i = dt; redir_valid_i = rv; redir_pc_i = rpc;
    upd_valid_i = uv; upd_pc_i = upc; upd_target_i = utg;
    #1;
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic [31:0] ins,
                      input logic dt, input logic [31:0] exp_pc, input logic exp_t);
    drive(pc, ins, dt, 1'b0, '0, 1'b0, '0, '0);
    chk(req, next_pc_o, exp_pc);
    chk(req, {31'd0, pred_taken_o}, {31'd0, exp_t});
  endtask

  localparam logic [21:0] TAG_A = 22'h12345, TAG_B = 22'h0ABCD;

  initial begin
    logic [31:0] p;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1: empty state
    look("R1", 32'h0000_0100, NOP, 1'b1, 32'h0000_0104, 1'b0);
    look("R1", pc_at(TAG_A, 3), NOP, 1'b1, pc_at(TAG_A, 3) + 4, 1'b0);
    look("R1", 32'h0000_0200, enc_jalr(0, 1), 1'b1, 32'h0000_0204, 1'b0);

    // R3: fill every index; write-cycle lookup sees old (invalid) entry
    for (int i = 0; i < 256; i++) begin
      p = pc_at(TAG_A, i);
      drive(p, NOP, 1'b1, 1'b0, '0, 1'b1, p, 32'h8000_0000 + i * 16);
      chk("R3", next_pc_o, p + 4);
    end
    // R2: hit taken, hit not taken, tag mismatch
    for (int i = 0; i < 256; i++) begin
      look("R2", pc_at(TAG_A, i), NOP, 1'b1, 32'h8000_0000 + i * 16, 1'b1);
      look("R2", pc_at(TAG_A, i), NOP, 1'b0, pc_at(TAG_A, i) + 4, 1'b0);
      look("R2", pc_at(TAG_B, i), NOP, 1'b1, pc_at(TAG_B, i) + 4, 1'b0);
    end
    // R3: replace index 5, lookup of old tag in write cycle still hits
    drive(pc_at(TAG_A, 5), NOP, 1'b1, 1'b0, '0, 1'b1, pc_at(TAG_B, 5), 32'h4000_0100);
    chk("R3", next_pc_o, 32'h8000_0050);
    look("R3", pc_at(TAG_A, 5), NOP, 1'b1, pc_at(TAG_A, 5) + 4, 1'b0);
    look("R3", pc_at(TAG_B, 5), NOP, 1'b1, 32'h4000_0100, 1'b1);

    // R4/R9: JAL offsets at a BTB-hit address
    for (int k = 0; k < 6; k++) begin
      logic [20:0] imm;
      case (k)
        0: imm = 21'd8;       1: imm = 21'h1FFFFC;  2: imm = 21'h0FFFFE;
        3: imm = 21'h100000;  4: imm = 21'h000800;  default: imm = 21'h000002;
      endcase
      p = pc_at(TAG_A, 7);
      look("R4", p, enc_jal(0, imm), 1'b1, p + {{11{imm[20]}}, imm}, 1'b1);
    end
    look("R6", 32'h0000_0200, enc_jalr(0, 1), 1'b0, 32'h0000_0204, 1'b0);

    // R5/R6/R10: calls and returns
    look("R5", 32'h0000_0300, enc_jal(1, 21'h40), 1'b0, 32'h0000_0340, 1'b1);
    look("R6", 32'h0000_0500, enc_jalr(0, 1), 1'b0, 32'h0000_0304, 1'b1);
    look("R6", 32'h0000_0500, enc_jalr(0, 1), 1'b0, 32'h0000_0504, 1'b0);
    look("R10", 32'h0000_0600, enc_jalr(5, 6), 1'b1, 32'h0000_0604, 1'b0);
    look("R6", 32'h0000_0700, enc_jalr(0, 6), 1'b1, 32'h0000_0704, 1'b0);
    look("R5", 32'h0000_0800, enc_jal(2, 21'd8), 1'b0, 32'h0000_0808, 1'b1);
    look("R10", 32'h0000_0900, enc_jalr(0, 5), 1'b0, 32'h0000_0604, 1'b1);
    look("R6", 32'h0000_0900, enc_jalr(0, 5), 1'b0, 32'h0000_0904, 1'b0);

    // R7: nine pushes, eight pops, then empty
    for (int k = 0; k < 9; k++)
      look("R7", 32'h1000 + k * 64, enc_jal(1, 21'h10), 1'b0, 32'h1010 + k * 64, 1'b1);
    for (int k = 8; k >= 1; k--)
      look("R7", 32'h2000, enc_jalr(0, 1), 1'b0, 32'h1004 + k * 64, 1'b1);
    look("R7", 32'h2000, enc_jalr(0, 1), 1'b0, 32'h2004, 1'b0);

    // R8: redirect against return, call and BTB hit
    look("R8", 32'h3000, enc_jal(1, 21'h20), 1'b0, 32'h3020, 1'b1);
    drive(32'h3100, enc_jalr(0, 1), 1'b0, 1'b1, 32'h5550, 1'b0, '0, '0);
    chk("R8", next_pc_o, 32'h5550);
    chk("R8", {31'd0, pred_taken_o}, 32'd0);
    drive(32'h3200, enc_jal(1, 21'h40), 1'b0, 1'b1, 32'h6660, 1'b0, '0, '0);
    chk("R8", next_pc_o, 32'h6660);
    chk("R8", {31'd0, pred_taken_o}, 32'd0);
    drive(pc_at(TAG_A, 9), NOP, 1'b1, 1'b1, 32'h7770, 1'b0, '0, '0);
    chk("R8", next_pc_o, 32'h7770);
    look("R8", 32'h3300, enc_jalr(0, 1), 1'b0, 32'h3004, 1'b1);
    look("R8", 32'h3300, enc_jalr(0, 1), 1'b0, 32'h3304, 1'b0);

    // R9: return over BTB, JAL over BTB
    look("R9", 32'h4000, enc_jal(1, 21'h80), 1'b0, 32'h4080, 1'b1);
    look("R9", pc_at(TAG_A, 10), enc_jalr(0, 1), 1'b1, 32'h4004, 1'b1);
    look("R9", pc_at(TAG_A, 11), enc_jal(0, 21'h20), 1'b1, pc_at(TAG_A, 11) + 32'h20, 1'b1);
    look("R9", pc_at(TAG_A, 12), NOP, 1'b1, 32'h8000_00C0, 1'b1);

    drive(32'h0, NOP, 1'b0, 1'b0, '0, 1'b0, '0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule